// File: doc/BRIEF.md
# Double-Buffered Backlight PWM Generator

This block drives a single pulse-width-modulated line that sets the brightness of a display backlight. A prescaler divides the input clock, a period counter steps on each prescaler tick, and a compare against a programmed high width decides the output level. Each period opens with the output high and drops it once the period counter reaches the high width.

Software programs the block through a small word-addressed register file with a single-cycle write strobe and a combinational read path. Divider, period and high width are written to shadow copies first. A commit write copies the whole shadow set into the working copy. The waveform logic takes the working set at the next period boundary, so a running waveform never sees a half-written or truncated period. A debug field with both bits set switches the block to direct mode. In direct mode, configuration writes go to the working copy at once and reads show the working values.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset every register reads as zero and `pwm_out` is low.
- R2: With divider d, period p and high width h, where 0 < h <= p, the output repeats every (d+1)*(p+1) clock cycles. It is high for the first (d+1)*h cycles of each period and low for the rest.
- R3: A high width of 0 keeps the output low for the whole period. A high width greater than p keeps it high for the whole period.
- R4: Bit 0 of word 0 is the enable. While it reads 0 the output is low. The first period begins one cycle after the enable write, so the output sample taken right after that write is still low. Clearing the enable forces the output low from the cycle after the write.
- R5: Outside direct mode, writes to word 1 (divider at bits [25:16]) and word 2 (period at bits [11:0], high width at bits [28:16]) change only the shadow copy. The waveform does not change until a write to word 3 with bit 0 set copies the shadow set to the working set.
- R6: A working set that changes while the waveform runs is used from the next period boundary on. The period in progress completes with its old values.
- R7: When bits [1:0] of word 4 are both 1 (direct mode), writes to words 1 and 2 update the working set directly, with no commit, and leave the shadow copy untouched.
- R8: Reads of words 1 and 2 return the working set in direct mode and the shadow set otherwise. Only the field bits can read as 1; every other bit reads 0.
- R9: Word 3 bit 0 and word 4 bits [1:0] read back the last value written, so software can clear the commit bit after use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe, one write per high cycle |
| reg_addr | input | 3 | Word address: 0 enable, 1 divider, 2 period/high width, 3 commit, 4 debug |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
The bench uses the default field widths but keeps the programmed values small: dividers 0 to 2, periods 0 to 3 and high widths 0 to 5. With these values the sweep covers every combination in under forty cycles each. Each run is compared cycle by cycle against the arithmetic waveform, so the zero-width and saturated-width corners fall inside the sweep. An eight-cycle period with no division puts a mid-period commit or a direct-mode write at an exactly known cycle, which makes the boundary at which the new values appear checkable. All-ones writes cover the full field widths for read-back masking.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int DIV_W    = 10;
  localparam int PER_W    = 12;
  localparam int HIGH_W   = 13;
  localparam int DBG_W    = 2;
  localparam int DIV_LSB  = 16;
  localparam int PER_LSB  = 0;
  localparam int HIGH_LSB = 16;
  localparam int EN_BIT   = 0;
  localparam int CMT_BIT  = 0;

  localparam logic [DBG_W-1:0] DBG_DIRECT = {DBG_W{1'b1}};

  typedef enum logic [ADDR_W-1:0] {
    RA_ENABLE = 3'd0,
    RA_CLKCFG = 3'd1,
    RA_WAVE   = 3'd2,
    RA_COMMIT = 3'd3,
    RA_DEBUG  = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [PER_W-1:0]  per;
    logic [HIGH_W-1:0] high;
  } wave_cfg_t;

endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output wave_cfg_t         work_o
);

  logic             en_q, en_d;
  logic             cmt_q, cmt_d;
  logic [DBG_W-1:0] dbg_q, dbg_d;
  wave_cfg_t        shadow_q, shadow_d;
  wave_cfg_t        work_q, work_d;

  logic      direct;
  logic      hit_en, hit_clk, hit_wave, hit_cmt, hit_dbg;
  logic      commit_hit;
  logic      shadow_ce, work_ce;
  wave_cfg_t view;

  assign direct   = (dbg_q == DBG_DIRECT);
  assign hit_en   = wr_i && (addr_i == RA_ENABLE);
  assign hit_clk  = wr_i && (addr_i == RA_CLKCFG);
  assign hit_wave = wr_i && (addr_i == RA_WAVE);
  assign hit_cmt  = wr_i && (addr_i == RA_COMMIT);
  assign hit_dbg  = wr_i && (addr_i == RA_DEBUG);

  assign commit_hit = hit_cmt && wdata_i[CMT_BIT];

  // Clock enables for the configuration copies
  assign shadow_ce = !direct && (hit_clk || hit_wave);
  assign work_ce   = direct ? (hit_clk || hit_wave) : commit_hit;

  // Next-state for simple control bits
  always_comb begin
    en_d  = en_q;
    cmt_d = cmt_q;
    dbg_d = dbg_q;
    if (hit_en)  en_d  = wdata_i[EN_BIT];
    if (hit_cmt) cmt_d = wdata_i[CMT_BIT];
    if (hit_dbg) dbg_d = wdata_i[DBG_W-1:0];
  end

  // Next-state for shadow copy
  always_comb begin
    shadow_d = shadow_q;
    if (hit_clk) begin
      shadow_d.div = wdata_i[DIV_LSB +: DIV_W];
    end
    if (hit_wave) begin
      shadow_d.per  = wdata_i[PER_LSB +: PER_W];
      shadow_d.high = wdata_i[HIGH_LSB +: HIGH_W];
    end
  end

  // Next-state for working copy: direct field write or full commit
  always_comb begin
    work_d = work_q;
    if (direct) begin
      if (hit_clk) begin
        work_d.div = wdata_i[DIV_LSB +: DIV_W];
      end
      if (hit_wave) begin
        work_d.per  = wdata_i[PER_LSB +: PER_W];
        work_d.high = wdata_i[HIGH_LSB +: HIGH_W];
      end
    end else begin
      work_d = shadow_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cmt_q <= 1'b0;
      dbg_q <= '0;
    end else begin
      en_q  <= en_d;
      cmt_q <= cmt_d;
      dbg_q <= dbg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (shadow_ce) begin
      shadow_q <= shadow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
    end else if (work_ce) begin
      work_q <= work_d;
    end
  end

  // Read path
  assign view = direct ? work_q : shadow_q;

  always_comb begin
    rdata_o = '0;
    case (reg_sel_e'(addr_i))
      RA_ENABLE: rdata_o[EN_BIT] = en_q;
      RA_CLKCFG: rdata_o[DIV_LSB +: DIV_W] = view.div;
      RA_WAVE: begin
        rdata_o[PER_LSB +: PER_W]   = view.per;
        rdata_o[HIGH_LSB +: HIGH_W] = view.high;
      end
      RA_COMMIT: rdata_o[CMT_BIT] = cmt_q;
      RA_DEBUG:  rdata_o[DBG_W-1:0] = dbg_q;
      default:   rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign work_o = work_q;

  AST_WORK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct && !commit_hit) |=> $stable(work_q)); // R5

  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct && commit_hit) |=> (work_q == $past(shadow_q))); // R5

  AST_SHADOW_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    direct |=> $stable(shadow_q)); // R7

endmodule

// File: rtl/bl_pwm_prescale.sv
module bl_pwm_prescale #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [W-1:0] lim_i,
  output logic         tick_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         at_lim;

  assign at_lim = (cnt_q == lim_i);

  always_comb begin
    if (clr_i) begin
      cnt_d = '0;
    end else if (at_lim) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = !clr_i && at_lim;

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |-> (cnt_q <= lim_i)); // R2

endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_i,
  input  wave_cfg_t work_i,
  output logic      pwm_o
);

  logic              run_q, run_d;
  logic [PER_W-1:0]  per_q, per_d;
  wave_cfg_t         act_q;
  logic              clr, tick, last_step, wrap, start, load;
  logic [HIGH_W-1:0] per_ext;

  assign clr   = !(run_q && en_i);
  assign start = en_i && !run_q;

  bl_pwm_prescale #(.W(DIV_W)) u_prescale (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .lim_i  (act_q.div),
    .tick_o (tick)
  );

  assign last_step = (per_q == act_q.per);
  assign wrap      = tick && last_step;
  assign load      = start || wrap;

  always_comb begin
    run_d = en_i;
    if (clr) begin
      per_d = '0;
    end else if (tick) begin
      per_d = last_step ? '0 : per_q + PER_W'(1);
    end else begin
      per_d = per_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      per_q <= '0;
    end else begin
      run_q <= run_d;
      per_q <= per_d;
    end
  end

  // Active copy, reloaded only when a period starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (load) begin
      act_q <= work_i;
    end
  end

  assign per_ext = HIGH_W'(per_q);
  assign pwm_o   = en_i && run_q && (per_ext < act_q.high);

  AST_PER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (per_q <= act_q.per)); // R2

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !(tick && per_q == act_q.per)) |=> $stable(act_q)); // R6

  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && run_q && (act_q.high > HIGH_W'(act_q.per))) |-> pwm_o); // R3

  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q.high == '0) |-> !pwm_o); // R3

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !pwm_o); // R4

endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_s;
  logic                   en;
  wave_cfg_t              work;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_s = rst_sync_q[SYNC_STAGES-1];

  bl_pwm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_i    (reg_wr),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .rdata_o (reg_rdata),
    .en_o    (en),
    .work_o  (work)
  );

  bl_pwm_core u_core (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .en_i   (en),
    .work_i (work),
    .pwm_o  (pwm_out)
  );

endmodule

// File: tb/bl_pwm_top_tb.sv
`timescale 1ns/1ps
module bl_pwm_top_tb_top;

  localparam logic [2:0] A_EN = 3'd0, A_CLK = 3'd1, A_WAVE = 3'd2,
                         A_CMT = 3'd3, A_DBG = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        pwm_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic wave [0:31];

  always #4 clk = ~clk;

  bl_pwm_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] ww(input int h, input int p);
    return (32'(h) << 16) | 32'(p);
  endfunction

  function automatic logic expo(input int i, input int d, input int p, input int h);
    return ((i / (d + 1)) % (p + 1)) < h;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int bad_j, cnt;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r);
      chk(r == 32'd0, "R1", $sformatf("reset read word %0d", a), r, 32'd0);
    end
    chk(pwm_out == 1'b0, "R1", "reset output", 32'(pwm_out), 32'd0);

    // R8 field masking on shadow read-back
    wr(A_CLK, 32'hFFFF_FFFF);
    rd(A_CLK, r);
    chk(r == 32'h03FF_0000, "R8", "divider mask", r, 32'h03FF_0000);
    wr(A_WAVE, 32'hFFFF_FFFF);
    rd(A_WAVE, r);
    chk(r == 32'h1FFF_0FFF, "R8", "wave mask", r, 32'h1FFF_0FFF);

    // R9 commit and debug read-back
    wr(A_CMT, 32'd1); rd(A_CMT, r);
    chk(r == 32'd1, "R9", "commit set", r, 32'd1);
    wr(A_CMT, 32'd0); rd(A_CMT, r);
    chk(r == 32'd0, "R9", "commit clear", r, 32'd0);
    wr(A_DBG, 32'd2); rd(A_DBG, r);
    chk(r == 32'd2, "R9", "debug readback", r, 32'd2);
    wr(A_DBG, 32'd0);

    // R2 / R3 / R4 sweep, cycle-exact
    for (int d = 0; d < 3; d++) begin
      for (int p = 0; p < 4; p++) begin
        for (int h = 0; h < 6; h++) begin
          int per_len;
          per_len = (d + 1) * (p + 1);
          wr(A_EN, 32'd0);
          wr(A_CLK, 32'(d) << 16);
          wr(A_WAVE, ww(h, p));
          wr(A_CMT, 32'd1);
          wr(A_CMT, 32'd0);
          wr(A_EN, 32'd1);
          bad_j = -1;
          for (int j = 0; j <= 2 * per_len; j++) begin
            logic e;
            @(negedge clk);
            e = (j == 0) ? 1'b0 : expo(j - 1, d, p, h);
            if (pwm_out !== e && bad_j < 0) bad_j = j;
          end
          chk(bad_j < 0, (h == 0 || h > p) ? "R3" : "R2",
              $sformatf("waveform d=%0d p=%0d h=%0d first bad sample", d, p, h),
              32'(bad_j), 32'hFFFF_FFFF);
        end
      end
    end

    // R6 commit in mid-period applies at boundary
    wr(A_EN, 32'd0);
    wr(A_CLK, 32'd0);
    wr(A_WAVE, ww(2, 7));
    wr(A_CMT, 32'd1);
    wr(A_CMT, 32'd0);
    wr(A_EN, 32'd1);
    fork
      begin
        for (int j = 0; j < 20; j++) begin
          @(negedge clk);
          wave[j] = pwm_out;
        end
      end
      begin
        wr(A_WAVE, ww(6, 7));
        wr(A_CMT, 32'd1);
        wr(A_CMT, 32'd0);
      end
    join
    bad_j = -1;
    for (int j = 1; j <= 16; j++) begin
      logic e;
      e = (j <= 8) ? expo(j - 1, 0, 7, 2) : expo(j - 1, 0, 7, 6);
      if (wave[j] !== e && bad_j < 0) bad_j = j;
    end
    chk(bad_j < 0, "R6", "commit boundary first bad sample", 32'(bad_j), 32'hFFFF_FFFF);

    // R5 shadow write without commit has no effect
    wr(A_WAVE, ww(1, 7));
    cnt = 0;
    for (int j = 0; j < 16; j++) begin
      @(negedge clk);
      if (pwm_out) cnt++;
    end
    chk(cnt == 12, "R5", "high count without commit", 32'(cnt), 32'd12);
    rd(A_WAVE, r);
    chk(r == ww(1, 7), "R8", "shadow read while buffered", r, ww(1, 7));

    // R3 full high, then R4 disable forces low
    wr(A_WAVE, ww(20, 3));
    wr(A_CMT, 32'd1);
    wr(A_CMT, 32'd0);
    repeat (16) @(negedge clk);
    cnt = 0;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (pwm_out) cnt++;
    end
    chk(cnt == 8, "R3", "saturated width high count", 32'(cnt), 32'd8);
    wr(A_EN, 32'd0);
    cnt = 0;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (pwm_out) cnt++;
    end
    chk(cnt == 0, "R4", "high count while disabled", 32'(cnt), 32'd0);
    rd(A_EN, r);
    chk(r == 32'd0, "R4", "enable readback", r, 32'd0);

    // R7 direct mode
    wr(A_WAVE, ww(5, 3));
    wr(A_DBG, 32'd3);
    rd(A_DBG, r);
    chk(r == 32'd3, "R9", "debug direct readback", r, 32'd3);
    wr(A_CLK, 32'd0);
    wr(A_WAVE, ww(2, 7));
    wr(A_EN, 32'd1);
    fork
      begin
        for (int j = 0; j < 20; j++) begin
          @(negedge clk);
          wave[j] = pwm_out;
        end
      end
      begin
        wr(A_WAVE, ww(6, 7));
      end
    join
    bad_j = -1;
    for (int j = 0; j <= 16; j++) begin
      logic e;
      if (j == 0) e = 1'b0;
      else e = (j <= 8) ? expo(j - 1, 0, 7, 2) : expo(j - 1, 0, 7, 6);
      if (wave[j] !== e && bad_j < 0) bad_j = j;
    end
    chk(bad_j < 0, "R7", "direct write first bad sample", 32'(bad_j), 32'hFFFF_FFFF);
    rd(A_WAVE, r);
    chk(r == ww(6, 7), "R8", "working read in direct mode", r, ww(6, 7));
    wr(A_DBG, 32'd0);
    rd(A_WAVE, r);
    chk(r == ww(5, 3), "R7", "shadow untouched by direct writes", r, ww(5, 3));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule